// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block keeps the sticky interrupt status of a UART and turns it into one interrupt line. The receiver reports break, parity, framing and receive-timeout conditions as one-cycle pulses. The transmit path supplies its FIFO fill level, whether the FIFO is in use, whether the serializer is idle and a strobe for each data write. From these the block decides when the transmit status rises and when it falls by itself.

Software reaches the block through a small register bus. A single-cycle write strobe updates the mask or the clear register, and reads are combinational. Four addresses are decoded: the raw status, the masked status, the mask and the write-one-to-clear register. All status fields share the bit positions 9 down to 5 in each register.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the raw status, the masked status and the mask all read 0, and `irqOut` is low.
- R2: A pulse on an event input sets its status bit at the next clock edge, and the bit then stays set. The bit positions are break 9, parity 8, framing 7, receive timeout 6 and transmit 5.
- R3: A bus write to address 3 clears every status bit whose position in the written data is 1. Bits written as 0 are unaffected. Address 3 reads as 0.
- R4: If a set and a clear reach the same status bit in the same cycle, the bit ends up set.
- R5: The receive-timeout bit reads as 1 in the raw status only while mask bit 6 is 1.
- R6: Address 0 returns the raw status, address 1 returns the raw status ANDed with the mask, and address 2 returns the mask. A write to address 2 loads the mask.
- R7: `irqOut` is a register holding the OR of the masked status. It rises one clock after a masked bit becomes visible.
- R8: The transmit trigger level depends on `trigSel`. Codes 0, 1, 2, 3 and 4 give 2, 4, 8, 12 and 14 entries. Codes 5 to 7 give 8 entries.
- R9: With `eotMode`=0 and the FIFO enabled, the transmit bit is set in a cycle where `txLevel` is at or below the trigger level and the previous cycle's level was above it.
- R10: With `eotMode`=1, the transmit bit is set only when `txIdle`=1 and `txLevel`=0 first hold together. Crossings of the trigger level do not set it.
- R11: With the FIFO enabled, the transmit bit is cleared in a cycle where `txLevel` is above the trigger level and the previous cycle's level was at or below it.
- R12: With the FIFO disabled, a `txPush` pulse clears the transmit bit, and a rise in level does not. The trigger level is then 0, so with `eotMode`=0 a fall of the level from 1 to 0 sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brkEvt | input | 1 | Break detected pulse |
| parEvt | input | 1 | Parity error pulse |
| frmEvt | input | 1 | Framing error pulse |
| rtoEvt | input | 1 | Receive timeout pulse |
| txLevel | input | 5 | Transmit FIFO fill level, 0 to 16 |
| fifoEn | input | 1 | Transmit FIFO in use |
| txIdle | input | 1 | Serializer has sent its last bit |
| eotMode | input | 1 | Transmit status follows end of transmission |
| txPush | input | 1 | One data word written to the transmitter |
| trigSel | input | 3 | Transmit trigger level code |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 5 | Write data, bit positions 9 to 5 |
| busRdata | output | 16 | Combinational read data |
| irqOut | output | 1 | Registered combined interrupt |

## Verification
The receive sources are driven through a table of pulse and clear patterns. The table includes simultaneous events, writes of all zeros, partial clears and a set colliding with a clear, so a wrong bit position, a clear that is too wide or a lost event each shows up. The transmit rules are swept over all eight trigger codes. For each code the level steps down to one entry above the trigger and then onto it, which separates the trigger levels from each other and shows whether the crossing comparison is exact. Further sequences cover each remaining rule on its own: the idle-based mode ignoring crossings, the two ways the transmit bit clears by itself, the receive-timeout gating by its mask bit, and the extra clock of latency on the interrupt line.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int FIELD_LO = 5;
  localparam int FIELD_HI = FIELD_LO + NUM_SRC - 1;

  localparam int SRC_TX  = 0;
  localparam int SRC_RTO = 1;
  localparam int SRC_FRM = 2;
  localparam int SRC_PAR = 3;
  localparam int SRC_BRK = 4;

  typedef enum logic [1:0] {
    RD_RAW    = 2'd0,
    RD_MASKED = 2'd1,
    RD_MASK   = 2'd2,
    RD_CLEAR  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [NUM_SRC-1:0] setVec;
    logic [NUM_SRC-1:0] clrVec;
    logic               maskWe;
    logic [NUM_SRC-1:0] maskVal;
    reg_sel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   brkEvt,
  input  logic                   parEvt,
  input  logic                   frmEvt,
  input  logic                   rtoEvt,
  input  logic [LVL_W-1:0]       txLevel,
  input  logic                   fifoEn,
  input  logic                   txIdle,
  input  logic                   eotMode,
  input  logic                   txPush,
  input  logic [2:0]             trigSel,
  input  logic                   busWr,
  input  logic [1:0]             busAddr,
  input  logic [FIELD_HI:FIELD_LO] busWdata,
  output strobe_t                strobes
);
  localparam logic [LVL_W-1:0] LVL_EIGHTH  = LVL_W'(FIFO_DEPTH / 8);
  localparam logic [LVL_W-1:0] LVL_QUARTER = LVL_W'(FIFO_DEPTH / 4);
  localparam logic [LVL_W-1:0] LVL_HALF    = LVL_W'(FIFO_DEPTH / 2);
  localparam logic [LVL_W-1:0] LVL_3Q      = LVL_W'((FIFO_DEPTH * 3) / 4);
  localparam logic [LVL_W-1:0] LVL_7E      = LVL_W'((FIFO_DEPTH * 7) / 8);

  logic [LVL_W-1:0] prevLevel;
  logic             idlePrev;
  logic [LVL_W-1:0] trigLvl;
  logic [LVL_W-1:0] threshold;
  logic             fallCross;
  logic             riseCross;
  logic             idleNow;
  logic             txSet;
  logic             txClr;
  reg_sel_e         addrSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevLevel <= '0;
      idlePrev  <= 1'b1;
    end else begin
      prevLevel <= txLevel;
      idlePrev  <= idleNow;
    end
  end

  always_comb begin
    case (trigSel)
      3'd0:    trigLvl = LVL_EIGHTH;
      3'd1:    trigLvl = LVL_QUARTER;
      3'd2:    trigLvl = LVL_HALF;
      3'd3:    trigLvl = LVL_3Q;
      3'd4:    trigLvl = LVL_7E;
      default: trigLvl = LVL_HALF;
    endcase
  end

  assign threshold = fifoEn ? trigLvl : '0;
  assign fallCross = (txLevel <= threshold) && (prevLevel > threshold);
  assign riseCross = (txLevel > threshold) && (prevLevel <= threshold);
  assign idleNow   = txIdle && (txLevel == '0);
  assign txSet     = eotMode ? (idleNow && !idlePrev) : fallCross;
  assign txClr     = fifoEn ? riseCross : txPush;
  assign addrSel   = reg_sel_e'(busAddr);

  always_comb begin
    strobes = '0;
    strobes.setVec[SRC_TX]  = txSet;
    strobes.setVec[SRC_RTO] = rtoEvt;
    strobes.setVec[SRC_FRM] = frmEvt;
    strobes.setVec[SRC_PAR] = parEvt;
    strobes.setVec[SRC_BRK] = brkEvt;
    if (busWr && addrSel == RD_CLEAR) strobes.clrVec = busWdata;
    strobes.clrVec[SRC_TX]  = strobes.clrVec[SRC_TX] | txClr;
    strobes.maskWe          = busWr && (addrSel == RD_MASK);
    strobes.maskVal         = busWdata;
    strobes.rdSel           = addrSel;
  end
endmodule

// File: rtl/uirq_dp.sv
module uirq_dp
  import uirq_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobe_t            strobes,
  output logic [NUM_SRC-1:0] statQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [BUS_W-1:0]   busRdata,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] statNext;
  logic [NUM_SRC-1:0] rawVis;
  logic [NUM_SRC-1:0] maskedVis;
  logic [NUM_SRC-1:0] fieldOut;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign statNext[i] = strobes.setVec[i] | (statQ[i] & ~strobes.clrVec[i]);
    if (i == SRC_RTO) begin : g_gated
      assign rawVis[i] = statQ[i] & maskQ[i];
    end else begin : g_plain
      assign rawVis[i] = statQ[i];
    end
  end

  assign maskedVis = rawVis & maskQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      statQ  <= '0;
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      statQ  <= statNext;
      irqOut <= |maskedVis;
      if (strobes.maskWe) maskQ <= strobes.maskVal;
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_RAW:    fieldOut = rawVis;
      RD_MASKED: fieldOut = maskedVis;
      RD_MASK:   fieldOut = maskQ;
      default:   fieldOut = '0;
    endcase
    busRdata = '0;
    busRdata[FIELD_LO +: NUM_SRC] = fieldOut;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int BUS_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     brkEvt,
  input  logic                     parEvt,
  input  logic                     frmEvt,
  input  logic                     rtoEvt,
  input  logic [LVL_W-1:0]         txLevel,
  input  logic                     fifoEn,
  input  logic                     txIdle,
  input  logic                     eotMode,
  input  logic                     txPush,
  input  logic [2:0]               trigSel,
  input  logic                     busWr,
  input  logic [1:0]               busAddr,
  input  logic [FIELD_HI:FIELD_LO] busWdata,
  output logic [BUS_W-1:0]         busRdata,
  output logic                     irqOut
);
  strobe_t            strobes;
  logic [NUM_SRC-1:0] statQ;
  logic [NUM_SRC-1:0] maskQ;

  uirq_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .brkEvt(brkEvt), .parEvt(parEvt), .frmEvt(frmEvt), .rtoEvt(rtoEvt),
    .txLevel(txLevel), .fifoEn(fifoEn), .txIdle(txIdle), .eotMode(eotMode),
    .txPush(txPush), .trigSel(trigSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .strobes(strobes)
  );

  uirq_dp #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .statQ(statQ), .maskQ(maskQ), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     brkEvt,
  input logic                     parEvt,
  input logic                     frmEvt,
  input logic                     rtoEvt,
  input logic                     busWr,
  input logic [1:0]               busAddr,
  input logic [FIELD_HI:FIELD_LO] busWdata,
  input logic [NUM_SRC-1:0]       statQ,
  input logic [NUM_SRC-1:0]       maskQ,
  input logic                     irqOut
);
  logic [NUM_SRC-1:0] evtVec;
  logic               clrWr;
  assign evtVec = {brkEvt, parEvt, frmEvt, rtoEvt, 1'b0};
  assign clrWr  = busWr && (busAddr == 2'd3);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (evtVec != '0) |=> ((statQ & $past(evtVec)) == $past(evtVec)));

  p_sticky_brk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (statQ[SRC_BRK] && !(clrWr && busWdata[FIELD_LO + SRC_BRK])) |=> statQ[SRC_BRK]);

  p_zero_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWr && busWdata == '0) |=> (statQ[NUM_SRC-1:1] == $past(statQ[NUM_SRC-1:1] | evtVec[NUM_SRC-1:1])));

  p_clear_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWr && busWdata[FIELD_LO + SRC_BRK] && !brkEvt) |=> !statQ[SRC_BRK]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWr && busWdata[FIELD_LO + SRC_PAR] && parEvt) |=> statQ[SRC_PAR]);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((statQ & maskQ) == '0) |=> !irqOut);

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((statQ & maskQ) != '0) |=> irqOut);
endmodule

bind uart_irq_status uirq_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .brkEvt(brkEvt), .parEvt(parEvt), .frmEvt(frmEvt), .rtoEvt(rtoEvt),
  .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .statQ(statQ), .maskQ(maskQ), .irqOut(irqOut)
);

// File: tb/uart_irq_status_bench.sv
module uart_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        brkEvt = 0, parEvt = 0, frmEvt = 0, rtoEvt = 0;
  logic [4:0]  txLevel = '0;
  logic        fifoEn = 1'b1, txIdle = 1'b0, eotMode = 1'b0, txPush = 1'b0;
  logic [2:0]  trigSel = '0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [9:5]  busWdata = '0;
  logic [15:0] busRdata;
  logic        irqOut;
  int          nChk = 0, nFail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  uart_irq_status u_uart_irq_status (
    .clk(clk), .rst_n(rst_n),
    .brkEvt(brkEvt), .parEvt(parEvt), .frmEvt(frmEvt), .rtoEvt(rtoEvt),
    .txLevel(txLevel), .fifoEn(fifoEn), .txIdle(txIdle), .eotMode(eotMode),
    .txPush(txPush), .trigSel(trigSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // [14:11] brk,par,frm,rto pulses; [10] clear write; [9:5] clear bits; [4:0] expected brk..tx
  localparam logic [14:0] VECS [11] = '{
    {4'b1000, 1'b0, 5'b00000, 5'b10000},
    {4'b0100, 1'b0, 5'b00000, 5'b11000},
    {4'b0011, 1'b0, 5'b00000, 5'b11110},
    {4'b0000, 1'b1, 5'b00000, 5'b11110},
    {4'b0000, 1'b1, 5'b10000, 5'b01110},
    {4'b0100, 1'b1, 5'b01000, 5'b01110},
    {4'b0000, 1'b1, 5'b01110, 5'b00000},
    {4'b1111, 1'b0, 5'b00000, 5'b11110},
    {4'b0000, 1'b1, 5'b11111, 5'b00000},
    {4'b0001, 1'b1, 5'b00010, 5'b00010},
    {4'b0000, 1'b1, 5'b00010, 5'b00000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    busWr = 1'b0; busAddr = a; #1; v = busRdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:5] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    cyc();
    busWr = 1'b0; busWdata = '0;
  endtask

  function automatic logic [4:0] trigOf(input int s);
    case (s)
      0: return 5'd2;
      1: return 5'd4;
      2: return 5'd8;
      3: return 5'd12;
      4: return 5'd14;
      default: return 5'd8;
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    logic [4:0]  t;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    rd(2'd0, v); check("R1 raw", v, 16'h0);
    rd(2'd1, v); check("R1 masked", v, 16'h0);
    rd(2'd2, v); check("R1 mask", v, 16'h0);
    check("R1 irq", {15'd0, irqOut}, 16'h0);

    // R2 R3 R4 vector table, mask fully open so bit 6 is visible
    wr(2'd2, 5'b11111);
    for (int i = 0; i < 11; i++) begin
      {brkEvt, parEvt, frmEvt, rtoEvt} = VECS[i][14:11];
      busWr = VECS[i][10]; busAddr = 2'd3; busWdata = VECS[i][9:5];
      cyc();
      {brkEvt, parEvt, frmEvt, rtoEvt} = 4'b0; busWr = 1'b0; busWdata = '0;
      rd(2'd0, v);
      check("R2/R3/R4 table", v, {6'd0, VECS[i][4:0], 5'd0});
    end

    // R8 R9 R11 trigger sweep
    for (int s = 0; s < 8; s++) begin
      t = trigOf(s);
      trigSel = 3'(s); txLevel = 5'd16; cyc(); cyc();
      wr(2'd3, 5'b00001);
      txLevel = t + 5'd1; cyc();
      rd(2'd0, v); check("R8 above trigger no set", v & 16'h20, 16'h0);
      txLevel = t; cyc();
      rd(2'd0, v); check("R9 falling crossing sets", v & 16'h20, 16'h20);
      txLevel = t + 5'd1; cyc();
      rd(2'd0, v); check("R11 rising crossing clears", v & 16'h20, 16'h0);
    end

    // R10 end-of-transmission mode
    eotMode = 1'b1; trigSel = 3'd2;
    txLevel = 5'd16; cyc(); cyc();
    wr(2'd3, 5'b00001);
    txLevel = 5'd8; cyc();
    rd(2'd0, v); check("R10 crossing ignored", v & 16'h20, 16'h0);
    txLevel = 5'd0; cyc();
    rd(2'd0, v); check("R10 not idle", v & 16'h20, 16'h0);
    txIdle = 1'b1; cyc();
    rd(2'd0, v); check("R10 idle sets", v & 16'h20, 16'h20);
    txIdle = 1'b0; eotMode = 1'b0; cyc();

    // R12 FIFO disabled
    fifoEn = 1'b0;
    txPush = 1'b1; cyc(); txPush = 1'b0;
    rd(2'd0, v); check("R12 push clears", v & 16'h20, 16'h0);
    txLevel = 5'd1; cyc();
    txLevel = 5'd0; cyc();
    rd(2'd0, v); check("R12 empty sets", v & 16'h20, 16'h20);
    txLevel = 5'd1; cyc();
    rd(2'd0, v); check("R12 level rise keeps", v & 16'h20, 16'h20);
    txLevel = 5'd0; cyc();
    wr(2'd3, 5'b11111);

    // R5 receive-timeout gating
    wr(2'd2, 5'b00000);
    rtoEvt = 1'b1; cyc(); rtoEvt = 1'b0;
    rd(2'd0, v); check("R5 gated off", v, 16'h0);
    wr(2'd2, 5'b00010);
    rd(2'd0, v); check("R5 visible", v, 16'h040);

    // R6 register views
    brkEvt = 1'b1; cyc(); brkEvt = 1'b0;
    rd(2'd0, v); check("R6 raw", v, 16'h240);
    rd(2'd1, v); check("R6 masked", v, 16'h040);
    rd(2'd2, v); check("R6 mask", v, 16'h040);
    rd(2'd3, v); check("R3 clear reads zero", v, 16'h0);

    // R7 registered interrupt
    wr(2'd2, 5'b00000); cyc();
    check("R7 irq low", {15'd0, irqOut}, 16'h0);
    wr(2'd2, 5'b10000);
    check("R7 irq one cycle late", {15'd0, irqOut}, 16'h0);
    cyc();
    check("R7 irq high", {15'd0, irqOut}, 16'h1);

    finishRun();
  end
endmodule